// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Wake Sequencer

This block runs next to a DRAM access controller and owns the row and column strobes whenever the memory needs housekeeping. After reset, or after a re-initialisation request (for example after a long stretch with supply present but clocks stopped), it waits out a power-up pause. It then issues a fixed number of wake-up cycles of the column-strobe-first type and only then reports the memory as ready. In those cycles the column strobe falls before the row strobe, so the device's own internal counter picks the row and no address is needed.

Once ready, the block divides the retention window into equal slots, one per row, and earns one owed refresh per slot. Owed refreshes pile up to a configurable cap while the access controller is busy. Each grant from the controller buys exactly one refresh cycle, which this block drives directly on the strobes. All delays are whole clock cycles, derived from a clock-frequency parameter.

Top module: `dram_refresh_seq`

## Requirements
- R1: After reset release or a re-init request, both strobes stay high for at least PAUSE_CYC = ceil(PAUSE_NS * CLK_HZ / 1e9) cycles. The first column-strobe fall comes no later than two cycles after that.
- R2: After the pause, exactly WAKE_CYCLES refresh cycles run back to back with no grant needed. init_done_o rises after the last of them.
- R3: While init_done_o is low, refresh_req_o is low and strobe_own_o is high.
- R4: In every refresh cycle, cas_n_o is low for exactly T_CSR cycles before ras_n_o falls, and it stays low for as long as ras_n_o is low.
- R5: ras_n_o stays low for exactly T_RAS cycles. It stays high for at least T_RP cycles between two low periods.
- R6: Once ready, one refresh is owed every SLOT_CYC = floor(RETENTION_NS * CLK_HZ / (1e9 * ROWS)) cycles. With grant held high, K slots yield exactly K refresh cycles.
- R7: Refreshes that are owed but not granted accumulate up to MAX_OWED and no further. A later grant then drains exactly MAX_OWED cycles, after which refresh_req_o drops.
- R8: A refresh cycle starts after ready only on a clock where grant_i and refresh_req_o are both high. A grant with nothing owed has no effect.
- R9: reinit_i drops init_done_o on the next cycle, discards every owed refresh, and restarts the pause and the wake-up cycles.
- R10: When strobe_own_o is low, ras_n_o and cas_n_o are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reinit_i | input | 1 | Restart pause and wake-up cycles |
| grant_i | input | 1 | Access controller hands the strobes over for one refresh |
| refresh_req_o | output | 1 | At least one refresh owed and engine idle |
| strobe_own_o | output | 1 | This block drives the strobes this cycle |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| init_done_o | output | 1 | Pause and wake-up cycles complete |

## Verification
Grant is tried in four patterns. Held high from reset, it shows that wake-up ignores grant and that a grant with nothing owed starts nothing, so the refresh count equals the slot count. Held low for several slots and then raised, it separates a correct owed cap from an unbounded or missing one. Random on/off bursts show that no cycle starts without a grant and that strobe shape holds across arbitrary arrival phases. A re-init from the running state shows that pending work is dropped and the full pause and wake-up sequence is repeated.

// File: rtl/drs_pkg.sv
package drs_pkg;

  typedef int unsigned uint_t;

  typedef enum logic [1:0] {
    SEQ_PAUSE,
    SEQ_WAKE,
    SEQ_RUN
  } seq_state_e;

  typedef enum logic [1:0] {
    CBR_IDLE,
    CBR_SETUP,
    CBR_RASLO,
    CBR_PRE
  } cbr_phase_e;

  localparam longint unsigned NS_PER_S = 64'd1_000_000_000;

  // Minimum waits round up so the wall-time floor is never undercut.
  function automatic longint unsigned ns_to_cycles_up(longint unsigned hz,
                                                      longint unsigned ns);
    return (hz * ns + NS_PER_S - 64'd1) / NS_PER_S;
  endfunction

  // Per-slot spacing rounds down so the full set fits inside the window.
  function automatic longint unsigned slot_cycles(longint unsigned hz,
                                                  longint unsigned window_ns,
                                                  longint unsigned slots);
    return (hz * window_ns) / (NS_PER_S * slots);
  endfunction

  // Bits needed to hold 0 .. v-1 (at least one).
  function automatic uint_t idx_bits(uint_t v);
    return (v < 2) ? 1 : $clog2(v);
  endfunction

endpackage

// File: rtl/drs_timer.sv
module drs_timer #(
  parameter int unsigned LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  output logic tick
);
  import drs_pkg::*;

  localparam uint_t CW = idx_bits(LIMIT);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  assign tick = en && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      cnt_q <= '0;
    end else if (en) begin
      cnt_q <= tick ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/drs_owed.sv
module drs_owed #(
  parameter int unsigned MAX_OWED = 8,
  parameter int unsigned OW       = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  input  logic          dec,
  output logic [OW-1:0] owed_o,
  output logic          any_o
);
  localparam logic [OW-1:0] CAP = OW'(MAX_OWED);

  logic [OW-1:0] owed_q;

  assign owed_o = owed_q;
  assign any_o  = (owed_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      owed_q <= '0;
    end else begin
      unique case ({inc, dec})
        2'b10:   if (owed_q != CAP) owed_q <= owed_q + 1'b1;
        2'b01:   if (owed_q != '0) owed_q <= owed_q - 1'b1;
        default: owed_q <= owed_q;
      endcase
    end
  end
endmodule

// File: rtl/drs_cbr_engine.sv
module drs_cbr_engine #(
  parameter int unsigned T_CSR = 2,
  parameter int unsigned T_RAS = 5,
  parameter int unsigned T_RP  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic ras_n,
  output logic cas_n,
  output logic idle,
  output logic done
);
  import drs_pkg::*;

  localparam uint_t LMAX = (T_CSR > T_RAS) ? ((T_CSR > T_RP) ? T_CSR : T_RP)
                                           : ((T_RAS > T_RP) ? T_RAS : T_RP);
  localparam uint_t CW = idx_bits(LMAX);

  cbr_phase_e    phase_q, phase_d;
  logic [CW-1:0] cnt_q;
  logic          last;
  logic          ras_n_q, cas_n_q;

  function automatic logic [CW-1:0] last_idx(cbr_phase_e p);
    case (p)
      CBR_SETUP: return CW'(T_CSR - 1);
      CBR_RASLO: return CW'(T_RAS - 1);
      CBR_PRE:   return CW'(T_RP - 1);
      default:   return '0;
    endcase
  endfunction

  assign last = (cnt_q == last_idx(phase_q));

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      CBR_IDLE:  if (start) phase_d = CBR_SETUP;
      CBR_SETUP: if (last)  phase_d = CBR_RASLO;
      CBR_RASLO: if (last)  phase_d = CBR_PRE;
      CBR_PRE:   if (last)  phase_d = CBR_IDLE;
      default:              phase_d = CBR_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= CBR_IDLE;
      cnt_q   <= '0;
      ras_n_q <= 1'b1;
      cas_n_q <= 1'b1;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= (phase_d != phase_q || phase_q == CBR_IDLE) ? '0 : cnt_q + 1'b1;
      cas_n_q <= !(phase_d == CBR_SETUP || phase_d == CBR_RASLO);
      ras_n_q <= !(phase_d == CBR_RASLO);
    end
  end

  assign ras_n = ras_n_q;
  assign cas_n = cas_n_q;
  assign idle  = (phase_q == CBR_IDLE);
  assign done  = (phase_q == CBR_PRE) && last;
endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq #(
  parameter longint unsigned CLK_HZ       = 100_000_000,
  parameter longint unsigned PAUSE_NS     = 200_000,
  parameter longint unsigned RETENTION_NS = 16_000_000,
  parameter int unsigned     ROWS         = 1024,
  parameter int unsigned     WAKE_CYCLES  = 8,
  parameter int unsigned     MAX_OWED     = 8,
  parameter int unsigned     T_CSR        = 2,
  parameter int unsigned     T_RAS        = 5,
  parameter int unsigned     T_RP         = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic reinit_i,
  input  logic grant_i,
  output logic refresh_req_o,
  output logic strobe_own_o,
  output logic ras_n_o,
  output logic cas_n_o,
  output logic init_done_o
);
  import drs_pkg::*;

  localparam uint_t PAUSE_CYC = uint_t'(ns_to_cycles_up(CLK_HZ, PAUSE_NS));
  localparam uint_t SLOT_CYC  = uint_t'(slot_cycles(CLK_HZ, RETENTION_NS, ROWS));
  localparam uint_t OW        = idx_bits(MAX_OWED + 1);
  localparam uint_t WW        = idx_bits(WAKE_CYCLES);
  localparam logic [WW-1:0] WAKE_LAST = WW'(WAKE_CYCLES - 1);

  seq_state_e    state_q;
  logic [WW-1:0] wake_cnt_q;

  // Named internal events, also seen by the bound checker.
  logic          pause_tick;
  logic          slot_tick;
  logic          eng_idle;
  logic          eng_done;
  logic          wake_start;
  logic          issue;
  logic          eng_start;
  logic          owed_any;
  logic [OW-1:0] owed;
  logic          in_run;

  assign in_run = (state_q == SEQ_RUN);

  drs_timer #(.LIMIT(PAUSE_CYC)) u_pause (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (reinit_i),
    .en   (state_q == SEQ_PAUSE && !reinit_i),
    .tick (pause_tick)
  );

  drs_timer #(.LIMIT(SLOT_CYC)) u_slot (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (reinit_i || !in_run),
    .en   (in_run),
    .tick (slot_tick)
  );

  drs_owed #(.MAX_OWED(MAX_OWED), .OW(OW)) u_owed (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (reinit_i || !in_run),
    .inc   (slot_tick),
    .dec   (issue),
    .owed_o(owed),
    .any_o (owed_any)
  );

  drs_cbr_engine #(.T_CSR(T_CSR), .T_RAS(T_RAS), .T_RP(T_RP)) u_engine (
    .clk  (clk),
    .rst_n(rst_n),
    .start(eng_start),
    .ras_n(ras_n_o),
    .cas_n(cas_n_o),
    .idle (eng_idle),
    .done (eng_done)
  );

  assign refresh_req_o = in_run && owed_any && eng_idle;
  assign issue         = refresh_req_o && grant_i;
  assign wake_start    = (state_q == SEQ_WAKE) && eng_idle && !reinit_i;
  assign eng_start     = wake_start || issue;

  always_ff @(posedge clk) begin
    if (!rst_n || reinit_i) begin
      state_q    <= SEQ_PAUSE;
      wake_cnt_q <= '0;
    end else begin
      unique case (state_q)
        SEQ_PAUSE: if (pause_tick) state_q <= SEQ_WAKE;
        SEQ_WAKE: begin
          if (eng_done) begin
            if (wake_cnt_q == WAKE_LAST) begin
              state_q    <= SEQ_RUN;
              wake_cnt_q <= '0;
            end else begin
              wake_cnt_q <= wake_cnt_q + 1'b1;
            end
          end
        end
        SEQ_RUN:  state_q <= SEQ_RUN;
        default:  state_q <= SEQ_PAUSE;
      endcase
    end
  end

  assign init_done_o  = in_run;
  assign strobe_own_o = !in_run || !eng_idle;
endmodule

// File: rtl/drs_chk.sv
module drs_chk #(
  parameter int unsigned MAX_OWED = 8,
  parameter int unsigned OW       = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reinit,
  input logic          grant,
  input logic          req,
  input logic          own,
  input logic          ras_n,
  input logic          cas_n,
  input logic          done,
  input logic [OW-1:0] owed,
  input logic          slot_tick,
  input logic          issue
);
  assert_cbr_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (!cas_n && $past(!cas_n)));

  assert_cas_covers_ras_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_n |-> !cas_n);

  assert_no_req_early_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> (!req && own));

  assert_owed_cap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    owed <= OW'(MAX_OWED));

  assert_slot_accrues_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_tick && !issue && !reinit && owed < OW'(MAX_OWED))
      |=> (owed == $past(owed) + 1'b1));

  assert_grant_gates_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cas_n) && done) |-> $past(grant && req));

  assert_idle_strobes_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !own |-> (ras_n && cas_n));

  assert_reinit_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    reinit |=> (!done && owed == '0));
endmodule

bind dram_refresh_seq drs_chk #(.MAX_OWED(MAX_OWED), .OW(OW)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .reinit   (reinit_i),
  .grant    (grant_i),
  .req      (refresh_req_o),
  .own      (strobe_own_o),
  .ras_n    (ras_n_o),
  .cas_n    (cas_n_o),
  .done     (init_done_o),
  .owed     (owed),
  .slot_tick(slot_tick),
  .issue    (issue)
);

// File: tb/dram_refresh_seq_tb_top.sv
module dram_refresh_seq_tb_top;
  localparam longint unsigned HZ     = 4_000_000;
  localparam longint unsigned P_NS   = 200_000;
  localparam longint unsigned RET_NS = 16_000_000;
  localparam int ROWS = 1024;
  localparam int WAKE = 8;
  localparam int MAXO = 4;
  localparam int TCSR = 2;
  localparam int TRAS = 4;
  localparam int TRP  = 3;
  localparam int CYC_LEN = TCSR + TRAS + TRP + 1;

  function automatic int exp_pause();
    longint unsigned prod = HZ * P_NS;
    longint unsigned q = prod / 64'd1000000000;
    if (q * 64'd1000000000 < prod) q = q + 1;
    return int'(q);
  endfunction

  function automatic int exp_slot();
    longint unsigned per_window = (HZ * RET_NS) / 64'd1000000000;
    return int'(per_window / ROWS);
  endfunction

  localparam int P    = exp_pause();
  localparam int SLOT = exp_slot();

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reinit = 1'b0;
  logic grant = 1'b0;
  logic req, own, ras_n, cas_n, init_done;

  dram_refresh_seq #(
    .CLK_HZ(HZ), .PAUSE_NS(P_NS), .RETENTION_NS(RET_NS), .ROWS(ROWS),
    .WAKE_CYCLES(WAKE), .MAX_OWED(MAXO), .T_CSR(TCSR), .T_RAS(TRAS), .T_RP(TRP)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .reinit_i(reinit), .grant_i(grant),
    .refresh_req_o(req), .strobe_own_o(own), .ras_n_o(ras_n),
    .cas_n_o(cas_n), .init_done_o(init_done)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int ras_falls = 0;
  logic ras_p = 1'b1, cas_p = 1'b1;
  int setup_len = 0, low_len = 0, high_len = 1000;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  task automatic step();
    @(negedge clk);
    #2;
  endtask

  // Strobe monitor, sampled on the falling edge.
  always @(negedge clk) begin
    if (rst_n) begin
      if (!init_done && (req || !own)) chk(0, "R3 req/own before ready", int'(req), 0);
      if (!own && (!ras_n || !cas_n)) chk(0, "R10 strobe active without ownership", int'(ras_n & cas_n), 1);
      if (!ras_n && cas_n) chk(0, "R4 cas high during ras low", 1, 0);
      if (cas_p && !cas_n && init_done && !grant) chk(0, "R8 cycle started without grant", 0, 1);
      if (ras_p && !ras_n) begin
        ras_falls++;
        chk(!cas_p && setup_len == TCSR, "R4 cas lead before ras", setup_len, TCSR);
        chk(high_len >= TRP, "R5 precharge width", high_len, TRP);
      end
      if (!ras_p && ras_n) chk(low_len == TRAS, "R5 ras low width", low_len, TRAS);
      if (!ras_n) low_len = ras_p ? 1 : low_len + 1;
      else        high_len = !ras_p ? 1 : high_len + 1;
      if (!cas_n && ras_n) setup_len = cas_p ? 1 : setup_len + 1;
      else if (cas_n)      setup_len = 0;
      ras_p = ras_n;
      cas_p = cas_n;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    summary();
    $finish;
  end

  initial begin
    int k;
    int f0;
    void'($urandom(32'd9173));
    grant = 1'b1;
    repeat (3) step();
    chk(!init_done && !req, "R3 reset state ready/req", int'(init_done | req), 0);
    chk(own, "R3 reset ownership", int'(own), 1);
    chk(ras_n && cas_n, "R10 reset strobes idle", int'(ras_n & cas_n), 1);
    rst_n = 1'b1;

    // R1 pause length after reset.
    k = 0;
    while (cas_n && k < 5000) begin step(); k++; end
    chk(k >= P && k <= P + 2, "R1 pause after reset", k, P + 1);
    chk(ras_falls == 0, "R1 no row strobe during pause", ras_falls, 0);

    // R2 wake-up burst, grant is ignored here.
    k = 0;
    while (!init_done && k < 1000) begin step(); k++; end
    chk(init_done, "R2 ready reached", int'(init_done), 1);
    chk(ras_falls == WAKE, "R2 wake-up cycle count", ras_falls, WAKE);
    chk(!req, "R2 nothing owed at ready", int'(req), 0);

    // R6 and R8: grant held, one refresh per slot, none extra.
    f0 = ras_falls;
    repeat (10 * SLOT + 15) step();
    chk(ras_falls - f0 == 10, "R6 refreshes per 10 slots", ras_falls - f0, 10);
    chk(!own, "R10 ownership released when idle", int'(own), 0);

    // R7 accumulation and cap.
    k = 0;
    while ((own || req) && k < 200) begin step(); k++; end
    grant = 1'b0;
    k = 0;
    while (!req && k < 200) begin step(); k++; end
    chk(req, "R7 request raised while ungranted", int'(req), 1);
    repeat ((MAXO + 1) * SLOT + 5) step();
    chk(req && ras_n && cas_n, "R7 still pending, strobes idle", int'(req), 1);
    f0 = ras_falls;
    grant = 1'b1;
    repeat (MAXO * CYC_LEN + 5) step();
    chk(ras_falls - f0 == MAXO, "R7 drained count equals cap", ras_falls - f0, MAXO);
    chk(!req, "R7 request dropped after drain", int'(req), 0);

    // Random grant bursts; the monitor checks R4, R5, R8, R10.
    f0 = ras_falls;
    for (int b = 0; b < 40; b++) begin
      grant = 1'($urandom_range(0, 1));
      repeat ($urandom_range(1, 40)) step();
    end
    grant = 1'b1;
    k = 0;
    while ((req || own) && k < 400) begin step(); k++; end
    chk(!req, "R8 random bursts drained", int'(req), 0);
    chk(ras_falls > f0, "R8 random bursts issued refreshes", ras_falls - f0, 1);

    // R9 re-init from idle running state.
    grant = 1'b0;
    k = 0;
    while (own && k < 200) begin step(); k++; end
    reinit = 1'b1;
    step();
    reinit = 1'b0;
    chk(!init_done, "R9 ready drops after reinit", int'(init_done), 0);
    chk(!req && own, "R9 request cleared, ownership taken", int'(req), 0);
    f0 = ras_falls;
    k = 0;
    while (cas_n && k < 5000) begin step(); k++; end
    chk(k >= P && k <= P + 2, "R9 pause repeated", k, P + 1);
    k = 0;
    while (!init_done && k < 1000) begin step(); k++; end
    chk(ras_falls - f0 == WAKE, "R9 wake-up repeated", ras_falls - f0, WAKE);
    chk(!req, "R9 owed refreshes discarded", int'(req), 0);

    summary();
    $finish;
  end
endmodule